// File: doc/BRIEF.md
# Frame-Pointer Relative Move and Push Unit

This execution unit runs two data-memory instructions that address memory relative to a 12-bit frame pointer. The move instruction spans two 16-bit words. Its first word carries a 7-bit source offset and its second word a 7-bit destination offset. The unit reads the byte at pointer plus source offset, then writes it at pointer plus destination offset. The push instruction is a single word. It stores an 8-bit literal at the pointer address and then steps the pointer down by one, so software can keep a downward-growing stack in data memory.

Instruction words arrive on a simple fetch interface. A busy output tells fetch to present the second move word in the following cycle. The unit drives one single-port synchronous memory: a read issued in one cycle returns its data in the next. Certain addresses get special treatment, and both lists are parameters. The indirect-access registers read back as zero and cannot take a move's write. The protected registers cannot take a move's write either. Other logic in the core sets the pointer through a load port. An asynchronous active-low reset clears the unit, and its release is synchronised to the clock inside the block.

Top module: `fp_xfer_unit`

## Requirements
- R1: After reset the pointer `fp` is 000h, and `busy`, `illegal`, `mem_rd` and `mem_wr` are all low.
- R2: A valid word whose bits [15:8] equal FAh is a push. In that same cycle the unit drives `mem_wr`=1, `mem_addr`=`fp` and `mem_wdata`= bits [7:0]. `busy` stays low.
- R3: After a push the pointer reads `fp`-1 modulo 4096, so a push at 000h leaves FFFh.
- R4: A valid word whose bits [15:7] equal 1_1101_0111b is the first move word. In that cycle the unit drives `busy`=1 and `mem_rd`=1, with `mem_addr` = `fp` + bits [6:0] modulo 4096. `mem_rd` and `mem_wr` are never high together.
- R5: In the next cycle the unit takes a valid word with bits [15:12]=1111b as the second move word. Bits [11:7] are ignored. It drives `mem_wr`=1 at `fp` + bits [6:0] modulo 4096, and `mem_wdata` equals the byte returned for the source read.
- R6: If the source address falls in an indirect-access range (FDBh–FDFh, FE3h–FE7h, FEBh–FEFh), the move writes 00h in place of the byte read.
- R7: If the destination address falls in an indirect-access range, `mem_wr` stays low during the second cycle, and the move still ends normally with no `illegal`.
- R8: If the destination address is protected (FF9h, FFDh, FFEh, FFFh), `mem_wr` stays low during the second cycle.
- R9: A move leaves `fp` unchanged.
- R10: `illegal` pulses for one cycle and no write occurs in either of two cases. The first is a valid idle-cycle word that is neither a push nor a first move word. The second is a second move cycle in which the word is missing or its bits [15:12] are not 1111b. After either, the unit is idle again.
- R11: When `fp_wr_en` is high, `fp` takes `fp_wr_data` at the next cycle. This load takes priority over a push decrement.
- R12: In an idle cycle with `instr_valid` low, the unit asserts no memory strobe, no `busy` and no `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Instruction word |
| busy | output | 1 | First move cycle; the second word is due next |
| illegal | output | 1 | Unrecognised word or bad second move word |
| fp_wr_en | input | 1 | Load the pointer |
| fp_wr_data | input | 12 | Pointer load value |
| fp | output | 12 | Current frame pointer |
| mem_addr | output | 12 | Data-memory address |
| mem_rd | output | 1 | Read strobe; data is returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |

## Verification
Moves are run with random pointers and offsets, and with sums that wrap past FFFh, so that a missing modulo or a swapped source and destination field shows up as a wrong address. Some moves are steered on purpose onto each indirect range and each protected address. These separate zeroing the source byte from suppressing the write, and indirect suppression from protected suppression. Pushes are chained from random pointers and from 000h, which exposes a wrong decrement order or a missing wrap. Malformed second words, absent second words and random illegal opcodes check that no stray write escapes. Pointer loads made at the same time as a push check that the load wins.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_MOVE2 = 1'b1
  } fpx_state_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_MOVE1 = 2'd2,
    OP_BAD   = 2'd3
  } fpx_op_e;

  // opcode fields; the bit positions are fixed by the instruction format
  localparam logic [7:0] PUSH_OPC  = 8'hFA;
  localparam logic [8:0] MOVE1_OPC = 9'b1_1101_0111;
  localparam logic [3:0] MOVE2_OPC = 4'hF;

  typedef struct packed {
    fpx_op_e    op;
    logic       word2_ok;
    logic [7:0] lit;
    logic [6:0] off;
  } fpx_dec_t;

endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
  import fpx_pkg::*;
(
  input  logic        valid,
  input  logic [15:0] word,
  output fpx_dec_t    dec
);

  logic is_push;
  logic is_move1;

  assign is_push  = (word[15:8] == PUSH_OPC);
  assign is_move1 = (word[15:7] == MOVE1_OPC);

  always_comb begin
    dec.lit      = word[7:0];
    dec.off      = word[6:0];
    dec.word2_ok = valid && (word[15:12] == MOVE2_OPC);
    if (!valid)        dec.op = OP_NONE;
    else if (is_push)  dec.op = OP_PUSH;
    else if (is_move1) dec.op = OP_MOVE1;
    else               dec.op = OP_BAD;
  end

endmodule

// File: rtl/fpx_addr_match.sv
module fpx_addr_match #(
  parameter int          AW   = 12,
  parameter int          N    = 4,
  parameter logic [N*AW-1:0] LIST = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = (addr == LIST[i*AW +: AW]);
  end

  assign hit = |eq;

endmodule

// File: rtl/fpx_pointer.sv
module fpx_pointer #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          dec_en,
  output logic [AW-1:0] q
);

  logic [AW-1:0] q_d;
  logic          q_en;

  always_comb begin
    q_en = load_en || dec_en;
    q_d  = q;
    if (load_en)     q_d = load_val;
    else if (dec_en) q_d = q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (q == $past(load_val)));

  assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load_en) |=> (q == $past(q) - AW'(1)));

endmodule

// File: rtl/fp_xfer_unit.sv
module fp_xfer_unit
  import fpx_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DW      = 8,
  parameter int N_INDIR = 15,
  parameter logic [N_INDIR*AW-1:0] INDIR_LIST = {
    12'hFDB, 12'hFDC, 12'hFDD, 12'hFDE, 12'hFDF,
    12'hFE3, 12'hFE4, 12'hFE5, 12'hFE6, 12'hFE7,
    12'hFEB, 12'hFEC, 12'hFED, 12'hFEE, 12'hFEF},
  parameter int N_PROT  = 4,
  parameter logic [N_PROT*AW-1:0] PROT_LIST = {
    12'hFF9, 12'hFFD, 12'hFFE, 12'hFFF}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [15:0]   instr_word,
  output logic          busy,
  output logic          illegal,
  input  logic          fp_wr_en,
  input  logic [AW-1:0] fp_wr_data,
  output logic [AW-1:0] fp,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int OW = 7;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // decode
  fpx_dec_t dec;

  fpx_decode u_dec (
    .valid (instr_valid),
    .word  (instr_word),
    .dec   (dec)
  );

  // one adder serves both offsets: both sit in bits [6:0] of their word
  logic [AW-1:0] rel_addr;
  assign rel_addr = fp + AW'({{(AW-OW){1'b0}}, dec.off});

  logic ind_hit;
  logic prot_hit;

  fpx_addr_match #(.AW(AW), .N(N_INDIR), .LIST(INDIR_LIST)) u_ind (
    .addr (rel_addr),
    .hit  (ind_hit)
  );

  fpx_addr_match #(.AW(AW), .N(N_PROT), .LIST(PROT_LIST)) u_prot (
    .addr (rel_addr),
    .hit  (prot_hit)
  );

  // state
  fpx_state_e state_q, state_d;
  logic       zero_src_q, zero_src_d;
  logic       zero_src_en;
  logic       dec_en;
  logic       is_idle;

  assign is_idle = (state_q == ST_IDLE);

  always_comb begin
    state_d     = ST_IDLE;
    zero_src_d  = zero_src_q;
    zero_src_en = 1'b0;
    dec_en      = 1'b0;
    busy        = 1'b0;
    illegal     = 1'b0;
    mem_rd      = 1'b0;
    mem_wr      = 1'b0;
    mem_addr    = fp;
    mem_wdata   = '0;
    if (is_idle) begin
      unique case (dec.op)
        OP_PUSH: begin
          mem_wr    = 1'b1;
          mem_addr  = fp;
          mem_wdata = dec.lit;
          dec_en    = 1'b1;
        end
        OP_MOVE1: begin
          busy        = 1'b1;
          mem_rd      = 1'b1;
          mem_addr    = rel_addr;
          state_d     = ST_MOVE2;
          zero_src_d  = ind_hit;
          zero_src_en = 1'b1;
        end
        OP_BAD:  illegal = 1'b1;
        default: ;
      endcase
    end else begin
      mem_addr = rel_addr;
      if (dec.word2_ok) begin
        mem_wr    = !(ind_hit || prot_hit);
        mem_wdata = zero_src_q ? '0 : mem_rdata;
      end else begin
        illegal = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       zero_src_q <= 1'b0;
    else if (zero_src_en) zero_src_q <= zero_src_d;
  end

  fpx_pointer #(.AW(AW)) u_fp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (fp_wr_en),
    .load_val (fp_wr_data),
    .dec_en   (dec_en),
    .q        (fp)
  );

  // checks next to the control logic
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mem_rd && mem_wr));

  assert_busy_single_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> !busy);

  assert_move_keeps_fp_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!is_idle && !fp_wr_en) |=> (fp == $past(fp)));

  assert_no_ind_write_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!is_idle && ind_hit) |-> !mem_wr);

  assert_no_prot_write_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!is_idle && prot_hit) |-> !mem_wr);

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    illegal |-> (!mem_wr && !busy));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_idle && !instr_valid) |-> !(mem_rd || mem_wr || busy || illegal));

endmodule

// File: tb/fp_xfer_unit_test.sv
module fp_xfer_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic        busy, illegal;
  logic        fp_wr_en;
  logic [11:0] fp_wr_data;
  logic [11:0] fp;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  fp_xfer_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .busy(busy), .illegal(illegal), .fp_wr_en(fp_wr_en), .fp_wr_data(fp_wr_data),
    .fp(fp), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // sparse memory model, one-cycle read latency
  logic [7:0] mem [int];

  function automatic logic [7:0] seed_byte(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] peek(input logic [11:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return seed_byte(a);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= peek(mem_addr);
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  function automatic bit is_indir(input logic [11:0] a);
    return (a >= 12'hFDB && a <= 12'hFDF) || (a >= 12'hFE3 && a <= 12'hFE7) ||
           (a >= 12'hFEB && a <= 12'hFEF);
  endfunction

  function automatic bit is_prot(input logic [11:0] a);
    return a == 12'hFF9 || a == 12'hFFD || a == 12'hFFE || a == 12'hFFF;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [11:0] exp_fp;

  task automatic set_fp(input logic [11:0] v);
    @(negedge clk);
    fp_wr_en = 1'b1; fp_wr_data = v;
    @(negedge clk);
    fp_wr_en = 1'b0;
    exp_fp = v;
    check("R11", "fp after load", fp, v);
  endtask

  task automatic do_push(input logic [7:0] k);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = {8'hFA, k};
    #2;
    check("R2", "push mem_wr", mem_wr, 1);
    check("R2", "push addr", mem_addr, exp_fp);
    check("R2", "push data", mem_wdata, k);
    check("R2", "push busy", busy, 0);
    @(negedge clk);
    instr_valid = 1'b0;
    exp_fp = exp_fp - 12'd1;
    check("R3", "fp after push", fp, exp_fp);
  endtask

  task automatic do_move(input logic [6:0] zs, input logic [6:0] zd,
                         input logic [4:0] dc);
    logic [11:0] sa, da;
    logic [7:0]  src;
    sa  = exp_fp + {5'd0, zs};
    da  = exp_fp + {5'd0, zd};
    src = is_indir(sa) ? 8'h00 : peek(sa);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = {9'b1_1101_0111, zs};
    #2;
    check("R4", "move busy", busy, 1);
    check("R4", "move rd", mem_rd, 1);
    check("R4", "move src addr", mem_addr, sa);
    @(negedge clk);
    instr_word = {4'hF, dc, zd};
    #2;
    check("R10", "move2 illegal", illegal, 0);
    if (is_indir(da)) check("R7", "indirect dst wr", mem_wr, 0);
    else if (is_prot(da)) check("R8", "protected dst wr", mem_wr, 0);
    else begin
      check("R5", "move wr", mem_wr, 1);
      check("R5", "move dst addr", mem_addr, da);
      if (is_indir(sa)) check("R6", "indirect src data", mem_wdata, 8'h00);
      else              check("R5", "move data", mem_wdata, src);
    end
    @(negedge clk);
    instr_valid = 1'b0;
    check("R9", "fp after move", fp, exp_fp);
  endtask

  task automatic do_illegal(input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    #2;
    check("R10", "illegal flag", illegal, 1);
    check("R10", "illegal wr", mem_wr, 0);
    @(negedge clk);
    instr_valid = 1'b0;
    check("R10", "fp after illegal", fp, exp_fp);
  endtask

  task automatic bad_second(input logic v, input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = {9'b1_1101_0111, 7'h01};
    @(negedge clk);
    instr_valid = v; instr_word = w;
    #2;
    check("R10", "bad word2 illegal", illegal, 1);
    check("R10", "bad word2 wr", mem_wr, 0);
    @(negedge clk);
    instr_valid = 1'b0;
    #2;
    check("R10", "idle after abort busy", busy, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
    fp_wr_en = 1'b0; fp_wr_data = '0;
    exp_fp = '0;
    repeat (3) @(negedge clk);
    #2;
    check("R1", "reset fp", fp, 0);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset illegal", illegal, 0);
    check("R1", "reset strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check("R12", "idle strobes", {mem_rd, mem_wr, busy, illegal}, 0);

    // directed corners
    set_fp(12'h1EC); do_push(8'h08);
    check("R2", "stored literal", peek(12'h1EC), 8'h08);
    set_fp(12'h000); do_push(8'hC3);
    set_fp(12'h080); do_move(7'h05, 7'h06, 5'h00);
    check("R5", "stored move byte", peek(12'h086), peek(12'h085));
    set_fp(12'hFD0); do_move(7'h0F, 7'h02, 5'h1F);
    check("R6", "zero stored", peek(12'hFD2), 8'h00);
    set_fp(12'hF80); do_move(7'h01, 7'h6D, 5'h0A);
    set_fp(12'hF80); do_move(7'h02, 7'h79, 5'h15);
    set_fp(12'hF80); do_move(7'h03, 7'h7F, 5'h03);
    set_fp(12'hFF0); do_move(7'h20, 7'h30, 5'h11);
    do_illegal(16'h0000);
    do_illegal(16'hEB00);
    bad_second(1'b1, 16'hE07F);
    bad_second(1'b0, 16'hF005);

    // load wins over push decrement
    set_fp(12'h300);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = 16'hFA77;
    fp_wr_en = 1'b1; fp_wr_data = 12'h555;
    @(negedge clk);
    instr_valid = 1'b0; fp_wr_en = 1'b0;
    exp_fp = 12'h555;
    check("R11", "load beats push", fp, 12'h555);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned sel;
      sel = $urandom % 10;
      if (sel < 3) begin
        do_push(8'($urandom));
      end else if (sel < 8) begin
        logic [6:0] zs, zd;
        if ($urandom % 4 == 0) set_fp(12'hF80 + 12'($urandom % 128));
        else if ($urandom % 3 == 0) set_fp(12'($urandom));
        zs = 7'($urandom); zd = 7'($urandom);
        do_move(zs, zd, 5'($urandom));
      end else if (sel < 9) begin
        logic [15:0] w;
        w = 16'($urandom);
        if (w[15:8] == 8'hFA || w[15:7] == 9'b1_1101_0111) w[15] = 1'b0;
        do_illegal(w);
      end else begin
        @(negedge clk);
        #2;
        check("R12", "idle no strobes", {mem_rd, mem_wr, busy, illegal}, 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule